// File: doc/BRIEF.md
# Hub Downstream Port Power Controller

This block switches power to the downstream ports of a USB hub. Hub logic presents one power-on request per port. The power-switch devices return one active-low overcurrent flag per port. The block drives one power-control line per port and keeps a sticky overcurrent status bit per port, which the host clears.

Three configuration straps fix how the block behaves. They select ganged or individual switching, enable or disable power management, and set the output polarity. All three are captured at the first clock edge after reset is released and stay frozen until the next reset. Overcurrent flags are synchronized and debounced before they act. In individual mode a fault removes power from the faulting port only. In ganged mode a fault removes power from every port. A port that lost power to a fault returns only after the host clears the status and the request is withdrawn and asserted again.

Top module: `hub_port_power`

## Requirements
- R1: The straps `strapGanged`, `strapPmDisable` and `strapActiveHigh` are captured at the first rising clock edge after `rstN` goes high. Later changes on them have no effect until the next reset.
- R2: With `strapActiveHigh`=1, a powered port drives its `pwrCtl` bit to 1. With `strapActiveHigh`=0, a powered port drives it to 0 and an unpowered port drives it to 1.
- R3: While `rstN` is low, and until the straps are captured, `pwrCtl` and `ocStatus` are all 0. Reset acts asynchronously.
- R4: In individual mode (`strapGanged`=0), port i is powered one clock after `pwrReq[i]` is sampled high and unpowered one clock after it is sampled low. Each port is independent of the other ports.
- R5: In ganged mode (`strapGanged`=1), all ports are powered when any `pwrReq` bit is 1, and all ports are unpowered when every bit is 0.
- R6: `ocN[i]`=0 means overcurrent. The low level passes through a two-flop synchronizer and must be seen for 8 consecutive cycles before it is acted on. A pulse of 7 cycles is ignored.
- R7: In individual mode, an accepted fault on port i sets `ocStatus[i]` and removes power from port i only, on the same clock edge.
- R8: In ganged mode, an accepted fault on port i sets `ocStatus[i]` and removes power from every port.
- R9: An `ocStatus` bit stays set until `ocClear` for that bit is sampled high. In individual mode, the port stays unpowered until its status is clear and `pwrReq[i]` has been sampled low. A later request then powers it.
- R10: In ganged mode, after a fault the ports stay unpowered until all faulted status bits are clear and all `pwrReq` bits have been sampled low.
- R11: With `strapPmDisable`=1, every port is driven to its powered level regardless of `pwrReq`. Overcurrent inputs are ignored and `ocStatus` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low global reset |
| strapGanged | input | 1 | 1 selects ganged switching, 0 selects individual switching |
| strapPmDisable | input | 1 | 1 disables power switching and overcurrent handling |
| strapActiveHigh | input | 1 | 1 makes the power outputs active high, 0 makes them active low |
| pwrReq | input | NUM_PORTS | Per-port power-on request from hub logic |
| ocN | input | NUM_PORTS | Per-port overcurrent flag, active low, asynchronous |
| ocClear | input | NUM_PORTS | Per-port clear strobe for the sticky status |
| pwrCtl | output | NUM_PORTS | Per-port power-switch control, polarity set by strap |
| ocStatus | output | NUM_PORTS | Per-port sticky overcurrent status |

## Verification
The properties assume that the straps are only meaningful while reset is held. They also assume that `ocClear` is a strobe the host raises only to acknowledge a set status bit. Every property therefore checks behaviour after strap capture and keys the sticky check on the cycle after `ocClear` is sampled. The stimulus changes straps only while `rstN` is low, except in the one test that shows later strap changes are ignored. It holds overcurrent levels for whole cycles, driven on the falling edge, so the debounce window is a known number of samples.

// File: rtl/hubPwrPkg.sv
package hubPwrPkg;
  // Configuration captured from the straps at reset release.
  typedef struct packed {
    logic strapsReady;  // straps have been captured
    logic activeHigh;   // output polarity
    logic pmEnable;     // power switching and overcurrent handling in use
    logic ganged;       // ganged switching policy
  } ppcCfg_t;
endpackage

// File: rtl/ocDebounce.sv
module ocDebounce #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic faultN,
  output logic eventPulse
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] SAT  = CW'(HOLD_CYCLES);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0] holdCnt;
  logic faultSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], ~faultN};
  end

  assign faultSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     holdCnt <= '0;
    else if (!enable || !faultSync) holdCnt <= '0;
    else if (holdCnt != SAT)       holdCnt <= holdCnt + 1'b1;
  end

  // One pulse on the sample that completes the hold window.
  assign eventPulse = enable && faultSync && (holdCnt == LAST);
endmodule

// File: rtl/ppcDatapath.sv
module ppcDatapath
  import hubPwrPkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ppcCfg_t              cfg,
  input  logic [NUM_PORTS-1:0] portOn,
  input  logic [NUM_PORTS-1:0] ocN,
  input  logic [NUM_PORTS-1:0] ocClear,
  output logic [NUM_PORTS-1:0] ocEvent,
  output logic [NUM_PORTS-1:0] ocStatus,
  output logic [NUM_PORTS-1:0] pwrCtl
);
  logic filterEn;
  logic [NUM_PORTS-1:0] statusQ;

  assign filterEn = cfg.strapsReady && cfg.pmEnable;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    ocDebounce #(
      .SYNC_STAGES(SYNC_STAGES),
      .HOLD_CYCLES(HOLD_CYCLES)
    ) uFilt (
      .clk       (clk),
      .rstN      (rstN),
      .enable    (filterEn),
      .faultN    (ocN[p]),
      .eventPulse(ocEvent[p])
    );
  end

  // A new event wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= ocEvent | (statusQ & ~ocClear);
  end

  assign ocStatus = statusQ;

  always_comb begin
    if (!cfg.strapsReady)    pwrCtl = '0;
    else if (cfg.activeHigh) pwrCtl = portOn;
    else                     pwrCtl = ~portOn;
  end
endmodule

// File: rtl/ppcControl.sv
module ppcControl
  import hubPwrPkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 strapGanged,
  input  logic                 strapPmDisable,
  input  logic                 strapActiveHigh,
  input  logic [NUM_PORTS-1:0] pwrReq,
  input  logic [NUM_PORTS-1:0] ocEvent,
  input  logic [NUM_PORTS-1:0] ocStatus,
  output ppcCfg_t              cfg,
  output logic [NUM_PORTS-1:0] portOn
);
  localparam logic [NUM_PORTS-1:0] ALL_ON = {NUM_PORTS{1'b1}};

  ppcCfg_t cfgQ;
  logic [NUM_PORTS-1:0] holdOff;
  logic [NUM_PORTS-1:0] portOnQ;
  logic [NUM_PORTS-1:0] portOnNext;
  logic anyReq;

  assign anyReq = |pwrReq;

  // Strap capture on the first edge after reset release.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (!cfgQ.strapsReady) begin
      cfgQ.strapsReady <= 1'b1;
      cfgQ.activeHigh  <= strapActiveHigh;
      cfgQ.pmEnable    <= ~strapPmDisable;
      cfgQ.ganged      <= strapGanged;
    end
  end

  // Per-port lockout after a fault: released once status is clear and
  // the request (or, when ganged, every request) has been withdrawn.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hold
    logic reqIdle;
    assign reqIdle = cfgQ.ganged ? !anyReq : !pwrReq[p];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          holdOff[p] <= 1'b0;
      else if (ocEvent[p])                holdOff[p] <= 1'b1;
      else if (!ocStatus[p] && reqIdle)   holdOff[p] <= 1'b0;
    end
  end

  always_comb begin
    if (!cfgQ.strapsReady) begin
      portOnNext = '0;
    end else if (!cfgQ.pmEnable) begin
      portOnNext = ALL_ON;
    end else if (cfgQ.ganged) begin
      portOnNext = (anyReq && !(|holdOff) && !(|ocEvent)) ? ALL_ON : '0;
    end else begin
      portOnNext = pwrReq & ~holdOff & ~ocEvent;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) portOnQ <= '0;
    else       portOnQ <= portOnNext;
  end

  assign cfg    = cfgQ;
  assign portOn = portOnQ;
endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
  import hubPwrPkg::*;
#(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 strapGanged,
  input  logic                 strapPmDisable,
  input  logic                 strapActiveHigh,
  input  logic [NUM_PORTS-1:0] pwrReq,
  input  logic [NUM_PORTS-1:0] ocN,
  input  logic [NUM_PORTS-1:0] ocClear,
  output logic [NUM_PORTS-1:0] pwrCtl,
  output logic [NUM_PORTS-1:0] ocStatus
);
  ppcCfg_t cfgBus;
  logic [NUM_PORTS-1:0] portOn;
  logic [NUM_PORTS-1:0] ocEvent;

  ppcControl #(.NUM_PORTS(NUM_PORTS)) uCtl (
    .clk            (clk),
    .rstN           (rstN),
    .strapGanged    (strapGanged),
    .strapPmDisable (strapPmDisable),
    .strapActiveHigh(strapActiveHigh),
    .pwrReq         (pwrReq),
    .ocEvent        (ocEvent),
    .ocStatus       (ocStatus),
    .cfg            (cfgBus),
    .portOn         (portOn)
  );

  ppcDatapath #(
    .NUM_PORTS  (NUM_PORTS),
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfgBus),
    .portOn  (portOn),
    .ocN     (ocN),
    .ocClear (ocClear),
    .ocEvent (ocEvent),
    .ocStatus(ocStatus),
    .pwrCtl  (pwrCtl)
  );
endmodule

// File: rtl/ppcChecker.sv
module ppcChecker
  import hubPwrPkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input ppcCfg_t              cfg,
  input logic [NUM_PORTS-1:0] portOn,
  input logic [NUM_PORTS-1:0] pwrCtl,
  input logic [NUM_PORTS-1:0] ocStatus,
  input logic [NUM_PORTS-1:0] ocClear
);
  localparam logic [NUM_PORTS-1:0] ONES = {NUM_PORTS{1'b1}};

  // R3
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.strapsReady |-> (pwrCtl == '0 && ocStatus == '0));

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.strapsReady |=> $stable(cfg));

  // R11
  pm_off_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strapsReady && !cfg.pmEnable) |=>
      (pwrCtl == (cfg.activeHigh ? ONES : '0) && ocStatus == '0));

  // R5
  ganged_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strapsReady && cfg.ganged) |-> (portOn == '0 || portOn == ONES));

  // R7
  fault_port_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strapsReady && cfg.pmEnable && !cfg.ganged) |-> ((portOn & ocStatus) == '0));

  // R8
  ganged_fault_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strapsReady && cfg.ganged && ocStatus != '0) |-> (portOn == '0));

  // R9
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ocStatus & ~ocClear) != '0) |=>
      ((ocStatus & $past(ocStatus & ~ocClear)) == $past(ocStatus & ~ocClear)));
endmodule

bind hub_port_power ppcChecker #(.NUM_PORTS(NUM_PORTS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .cfg     (cfgBus),
  .portOn  (portOn),
  .pwrCtl  (pwrCtl),
  .ocStatus(ocStatus),
  .ocClear (ocClear)
);

// File: tb/sim_hub_port_power.sv
module sim_hub_port_power;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapGanged = 1'b0;
  logic strapPmDisable = 1'b0;
  logic strapActiveHigh = 1'b1;
  logic [N-1:0] pwrReq = '0;
  logic [N-1:0] ocN = '1;
  logic [N-1:0] ocClear = '0;
  logic [N-1:0] pwrCtl;
  logic [N-1:0] ocStatus;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hub_port_power #(.NUM_PORTS(N)) u0 (
    .clk(clk), .rstN(rstN), .strapGanged(strapGanged),
    .strapPmDisable(strapPmDisable), .strapActiveHigh(strapActiveHigh),
    .pwrReq(pwrReq), .ocN(ocN), .ocClear(ocClear),
    .pwrCtl(pwrCtl), .ocStatus(ocStatus)
  );

  // {request, expected pwrCtl}: individual, active high, management on
  localparam logic [7:0] VEC [8] = '{
    8'b0000_0000, 8'b0001_0001, 8'b0011_0011, 8'b1010_1010,
    8'b1111_1111, 8'b0100_0100, 8'b1001_1001, 8'b0000_0000
  };

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset(input logic g, input logic pmOff, input logic hi);
    @(negedge clk);
    rstN = 1'b0;
    pwrReq = '0; ocN = '1; ocClear = '0;
    strapGanged = g; strapPmDisable = pmOff; strapActiveHigh = hi;
    step(3);
    rstN = 1'b1;
    step(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R3: held in reset with active-low strap, outputs stay 0
    strapActiveHigh = 1'b0;
    step(3);
    check("R3 pwrCtl in reset", pwrCtl, 4'b0000);
    check("R3 ocStatus in reset", ocStatus, 4'b0000);

    doReset(1'b0, 1'b0, 1'b1);
    check("R4 idle after reset", pwrCtl, 4'b0000);

    // R4 / R2: table walk
    for (int i = 0; i < 8; i++) begin
      pwrReq = VEC[i][7:4];
      step(1);
      check("R4 vector", pwrCtl, VEC[i][3:0]);
    end

    // R1: strap flip after capture is ignored
    strapActiveHigh = 1'b0;
    strapGanged = 1'b1;
    pwrReq = 4'b0011;
    step(1);
    check("R1 straps frozen", pwrCtl, 4'b0011);
    strapActiveHigh = 1'b1;
    strapGanged = 1'b0;

    // R6: 7-cycle low pulse rejected
    pwrReq = 4'b1111;
    step(1);
    ocN[2] = 1'b0;
    step(7);
    ocN[2] = 1'b1;
    step(12);
    check("R6 short pulse status", ocStatus, 4'b0000);
    check("R6 short pulse power", pwrCtl, 4'b1111);

    // R6 / R7: 8-cycle pulse accepted, only port 2 off
    ocN[2] = 1'b0;
    step(8);
    ocN[2] = 1'b1;
    step(4);
    check("R6 accepted status", ocStatus, 4'b0100);
    check("R7 only port 2 off", pwrCtl, 4'b1011);

    // R9: sticky, clear, re-request
    step(5);
    check("R9 status sticky", ocStatus, 4'b0100);
    ocClear[2] = 1'b1;
    step(1);
    ocClear[2] = 1'b0;
    check("R9 status cleared", ocStatus, 4'b0000);
    step(2);
    check("R9 still off without new request", pwrCtl, 4'b1011);
    pwrReq = 4'b1011;
    step(1);
    pwrReq = 4'b1111;
    step(1);
    check("R9 repowered", pwrCtl, 4'b1111);

    // R2: active-low polarity
    doReset(1'b0, 1'b0, 1'b0);
    check("R2 active low idle", pwrCtl, 4'b1111);
    pwrReq = 4'b0101;
    step(1);
    check("R2 active low on", pwrCtl, 4'b1010);

    // R5: ganged
    doReset(1'b1, 1'b0, 1'b1);
    check("R5 ganged idle", pwrCtl, 4'b0000);
    pwrReq = 4'b0010;
    step(1);
    check("R5 ganged one request", pwrCtl, 4'b1111);
    pwrReq = 4'b0000;
    step(1);
    check("R5 ganged release", pwrCtl, 4'b0000);

    // R8 / R10: ganged fault
    pwrReq = 4'b0001;
    step(1);
    ocN[3] = 1'b0;
    step(10);
    ocN[3] = 1'b1;
    step(3);
    check("R8 ganged status", ocStatus, 4'b1000);
    check("R8 ganged all off", pwrCtl, 4'b0000);
    ocClear[3] = 1'b1;
    step(1);
    ocClear[3] = 1'b0;
    step(2);
    check("R10 ganged held off", pwrCtl, 4'b0000);
    pwrReq = 4'b0000;
    step(1);
    pwrReq = 4'b0001;
    step(1);
    check("R10 ganged repowered", pwrCtl, 4'b1111);

    // R11: management disabled, active low
    doReset(1'b0, 1'b1, 1'b0);
    check("R11 all on without request", pwrCtl, 4'b0000);
    ocN = 4'b0000;
    step(14);
    check("R11 overcurrent ignored status", ocStatus, 4'b0000);
    check("R11 overcurrent ignored power", pwrCtl, 4'b0000);
    ocN = 4'b1111;

    // R3: asynchronous reset mid-operation
    doReset(1'b0, 1'b0, 1'b1);
    pwrReq = 4'b1111;
    step(1);
    check("R3 before reset", pwrCtl, 4'b1111);
    rstN = 1'b0;
    #1;
    check("R3 async reset power", pwrCtl, 4'b0000);
    check("R3 async reset status", ocStatus, 4'b0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule